// File: doc/BRIEF.md
# Programmable Delay and Pulse-Width Generator

This block is a clocked model of a programmable delay element. Time is counted in system clock cycles. A single-bit input waveform is stored in a history shift register. Two outputs are taken from it. The position of the main output's tap is set by an 8-bit code. Every path carries a fixed base offset of `BASE_DLY` cycles. A reference tap sits one cycle beyond that offset, so a code of 0 never arrives later than the reference copy.

A mode select chooses what the two outputs carry. In delay mode (mode 0), `main_o` is a same-polarity delayed copy of the input and `aux_o` is the reference copy. In pulse mode (mode 1), `main_o` is the inverted delayed copy. Feeding it back to the input outside the block makes a free-running oscillator. In the same mode, `aux_o` is a one-shot pulse. The pulse is started by a rising input edge, begins after the base offset and lasts for code cycles. It cannot be retriggered.

Because the whole waveform is kept, the delay may be far longer than the input high or low time, and every transition comes out in order.

Top module: `prog_delay_gen`

## Requirements
- R1: While `rst_ni` is low, the input history and the pulse state are cleared. `aux_o` is 0 and `main_o` equals `mode_i`: low in delay mode, high in the inverted mode. Input values from before a reset never appear at the outputs after it.
- R2: In mode 0, `main_o` after clock edge n equals `sig_i` sampled at edge n-(BASE_DLY+code). Here code is the unsigned value of `code_i` at edge n and BASE_DLY defaults to 2. Samples from before reset count as 0.
- R3: A code of 255 gives the longest delay, BASE_DLY+255 cycles.
- R4: In mode 0, `aux_o` after edge n equals `sig_i` sampled at edge n-(BASE_DLY+1).
- R5: In mode 1, `main_o` is the logical inverse of the R2 delayed copy, with the same delay.
- R6: Take a rising input edge: `sig_i` is 1 at edge e and 0 at edge e-1. If the one-shot is idle and `code_i` holds a nonzero value c at edge e+BASE_DLY, the pulse is high after edges e+BASE_DLY through e+BASE_DLY+c-1 and low after edge e+BASE_DLY+c. In mode 1 this pulse appears on `aux_o`.
- R7: The one-shot ignores a rising edge whose trigger edge (e+BASE_DLY) falls in the range from the first pulse-high edge + 1 up to and including the edge at which the pulse returns low.
- R8: A code of 0 at the trigger edge produces no pulse, and `aux_o` stays low in mode 1.
- R9: When the delay is longer than the input high and low times, every input transition is reproduced in order at the R2 timing.
- R10: A change of `code_i` takes effect at the next clock edge. Each output value uses the code sampled at that edge, and the output changes only at clock edges.
- R11: `mode_i` selects the outputs combinationally. The reference tap and the one-shot keep running in both modes, so switching modes shows their current state immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Input waveform |
| code_i | input | 8 | Delay or pulse-width code, unsigned |
| mode_i | input | 1 | 0: delayed and reference outputs; 1: inverted delayed output and pulse |
| main_o | output | 1 | Delayed copy (mode 0) or inverted delayed copy (mode 1) |
| aux_o | output | 1 | Reference copy (mode 0) or one-shot pulse (mode 1) |

## Verification
The hardest case to reach from the ports is a rising edge whose delayed trigger lands exactly on the edge where the one-shot returns low. That edge must be ignored, but the edge one cycle later must be accepted. The stimulus reaches it by driving input rises spaced exactly code cycles apart, and also spaced more tightly. A second hard case is stale history surviving a reset. It is covered by resetting in the middle of long-delay activity and then watching the maximum-delay tap for a full window with the input held low.

// File: rtl/prog_dly_pkg.sv
`timescale 1ns/1ps
package prog_dly_pkg;
  typedef enum logic {
    MODE_DELAY = 1'b0,
    MODE_PULSE = 1'b1
  } dly_mode_e;

  function automatic int unsigned hist_depth(input int unsigned base_dly, input int unsigned code_w);
    return base_dly + (32'd1 << code_w) - 1;
  endfunction
endpackage

// File: rtl/dly_history.sv
`timescale 1ns/1ps
module dly_history #(
  parameter int unsigned DEPTH = 257
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  output logic [DEPTH-1:0] hist_o
);
  // hist_o[k] holds the input sampled k+1 edges ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_o[0] <= 1'b0;
    else         hist_o[0] <= sig_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_o[k] <= 1'b0;
      else         hist_o[k] <= hist_o[k-1];
    end
  end
endmodule

// File: rtl/dly_tap_sel.sv
`timescale 1ns/1ps
module dly_tap_sel #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned BASE_DLY = 2,
  parameter int unsigned DEPTH    = 257
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEPTH-1:0]  hist_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              dly_o,
  output logic              ref_o
);
  localparam int unsigned IdxW = $clog2(DEPTH);

  logic [IdxW-1:0] tap_idx;
  assign tap_idx = IdxW'(BASE_DLY - 1) + IdxW'(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_o <= 1'b0;
      ref_o <= 1'b0;
    end else begin
      dly_o <= hist_i[tap_idx];
      ref_o <= hist_i[BASE_DLY];
    end
  end
endmodule

// File: rtl/pwm_oneshot.sv
`timescale 1ns/1ps
module pwm_oneshot #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tap_new_i,
  input  logic              tap_old_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o
);
  logic [CODE_W-1:0] remain_q;
  logic              rise;

  assign rise = tap_new_i & ~tap_old_i;

  // pulse_o doubles as the busy flag: no retrigger while high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o  <= 1'b0;
      remain_q <= '0;
    end else if (pulse_o) begin
      if (remain_q == '0) pulse_o  <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end else if (rise && code_i != '0) begin
      pulse_o  <= 1'b1;
      remain_q <= code_i - 1'b1;
    end
  end
endmodule

// File: rtl/prog_delay_gen.sv
`timescale 1ns/1ps
module prog_delay_gen
  import prog_dly_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned BASE_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              mode_i,
  output logic              main_o,
  output logic              aux_o
);
  localparam int unsigned Depth = hist_depth(BASE_DLY, CODE_W);

  logic [Depth-1:0] hist;
  logic             dly_q, ref_q, pulse_q;
  dly_mode_e        mode;

  dly_history #(.DEPTH(Depth)) u_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sig_i),
    .hist_o(hist)
  );

  dly_tap_sel #(.CODE_W(CODE_W), .BASE_DLY(BASE_DLY), .DEPTH(Depth)) u_tap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hist_i(hist),
    .code_i(code_i),
    .dly_o (dly_q),
    .ref_o (ref_q)
  );

  // trigger on the edge seen BASE_DLY cycles late, aligned with the code-0 tap
  pwm_oneshot #(.CODE_W(CODE_W)) u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tap_new_i(hist[BASE_DLY-1]),
    .tap_old_i(hist[BASE_DLY]),
    .code_i   (code_i),
    .pulse_o  (pulse_q)
  );

  assign mode   = dly_mode_e'(mode_i);
  assign main_o = (mode == MODE_PULSE) ? ~dly_q : dly_q;
  assign aux_o  = (mode == MODE_PULSE) ? pulse_q : ref_q;
endmodule

// File: rtl/prog_delay_gen_chk.sv
`timescale 1ns/1ps
module prog_delay_gen_chk #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned BASE_DLY = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sig_i,
  input logic [CODE_W-1:0] code_i,
  input logic              mode_i,
  input logic              main_o,
  input logic              aux_o
);
  // shist[k] holds the input sampled k+1 edges ago
  logic [BASE_DLY+1:0] shist;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shist <= '0;
    else         shist <= {shist[BASE_DLY:0], sig_i};
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_outputs_chk: assert (aux_o == 1'b0 && main_o == mode_i);
    end
  end

  // R2
  base_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && $past(code_i) == '0) |-> main_o == shist[BASE_DLY]);

  // R4
  ref_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> aux_o == shist[BASE_DLY+1]);

  // R5
  inv_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $past(code_i) == '0) |-> main_o == !shist[BASE_DLY]);

  // R6
  pulse_trigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $past(mode_i) && $rose(aux_o)) |-> (shist[BASE_DLY] && !shist[BASE_DLY+1]));

  // R8
  pulse_zero_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $past(mode_i) && $rose(aux_o)) |-> $past(code_i) != '0);
endmodule

bind prog_delay_gen prog_delay_gen_chk #(.CODE_W(CODE_W), .BASE_DLY(BASE_DLY)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sig_i (sig_i),
  .code_i(code_i),
  .mode_i(mode_i),
  .main_o(main_o),
  .aux_o (aux_o)
);

// File: tb/prog_delay_gen_tb.sv
`timescale 1ns/1ps
module prog_delay_gen_tb;
  localparam int BASE = 2;
  localparam int HMAX = 8192;

  typedef struct {
    logic  exp_main;
    logic  exp_aux;
    string req_main;
    string req_aux;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sig = 1'b0;
  logic [7:0] code = 8'd0;
  logic       mode = 1'b0;
  logic       main_o, aux_o;

  int    total = 0;
  int    fails = 0;
  bit    done = 1'b0;
  int    n = 0;
  int    epoch = 0;
  int    pstart = 0;
  int    pend = -1;
  logic  sh [HMAX];
  item_t sb_q[$];

  always #5 clk = ~clk;

  prog_delay_gen u_dut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .sig_i (sig),
    .code_i(code),
    .mode_i(mode),
    .main_o(main_o),
    .aux_o (aux_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (cycle %0d)", req, act, exp, n);
    end
  endtask

  function automatic logic sig_at(input int k);
    if (k < epoch) return 1'b0;
    return sh[k];
  endfunction

  // drive one cycle and queue the outputs expected after its edge
  task automatic step(input logic s, input int c, input logic m, input string rm, input string ra);
    item_t it;
    logic  d, pw;
    @(negedge clk);
    rst_ni = 1'b1;
    sig = s;
    code = 8'(c);
    mode = m;
    sh[n] = s;
    d = sig_at(n - BASE - c);
    if (sig_at(n - BASE) && !sig_at(n - BASE - 1) && n > pend && c != 0) begin
      pstart = n;
      pend = n + c;
    end
    pw = (n >= pstart) && (n < pend);
    it.exp_main = m ? ~d : d;
    it.exp_aux = m ? pw : sig_at(n - BASE - 1);
    it.req_main = rm;
    it.req_aux = ra;
    sb_q.push_back(it);
    @(posedge clk);
    n++;
  endtask

  // R1: async reset; the next step releases it
  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    sig = 1'b0;
    mode = 1'b0;
    #1;
    chk("R1", main_o, 1'b0);
    chk("R1", aux_o, 1'b0);
    mode = 1'b1;
    #1;
    chk("R1", main_o, 1'b1);
    chk("R1", aux_o, 1'b0);
    repeat (2) @(negedge clk);
    epoch = n;
    pstart = 0;
    pend = -1;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        chk(it.req_main, main_o, it.exp_main);
        chk(it.req_aux, aux_o, it.exp_aux);
      end
    end
  end

  task automatic report();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin : driver
    int hold;
    logic lvl;
    do_reset();
    // R2: base offset and small codes
    for (int i = 0; i < 40; i++) step(1'($urandom_range(0, 1)), 0, 1'b0, "R2", "R4");
    for (int i = 0; i < 40; i++) step(1'($urandom_range(0, 1)), 5, 1'b0, "R2", "R4");
    // R3: longest delay, short pulses
    lvl = 1'b0; hold = 0;
    for (int i = 0; i < 600; i++) begin
      if (hold == 0) begin lvl = ~lvl; hold = $urandom_range(1, 6); end
      hold--;
      step(lvl, 255, 1'b0, "R3", "R4");
    end
    // R9: delay longer than every high and low time
    for (int i = 0; i < 200; i++) begin
      if (hold == 0) begin lvl = ~lvl; hold = $urandom_range(1, 4); end
      hold--;
      step(lvl, 40, 1'b0, "R9", "R4");
    end
    // R5 and R6: inverted path with pulses
    for (int i = 0; i < 150; i++) step(1'($urandom_range(0, 1)), 17, 1'b1, "R5", "R6");
    for (int i = 0; i < 120; i++) step(1'((i % 30) < 3), 7, 1'b1, "R5", "R6");
    // R7: rises spaced exactly the code apart, then tighter
    for (int i = 0; i < 120; i++) step(1'((i % 6) < 2), 6, 1'b1, "R5", "R7");
    for (int i = 0; i < 120; i++) step(1'((i % 4) < 1), 20, 1'b1, "R5", "R7");
    // R8: code 0 never pulses
    for (int i = 0; i < 60; i++) step(1'((i % 5) < 2), 0, 1'b1, "R5", "R8");
    // R10: code changes every cycle
    for (int i = 0; i < 200; i++) step(1'($urandom_range(0, 1)), $urandom_range(0, 12), 1'b0, "R10", "R4");
    // R11: mode switches on the fly
    for (int i = 0; i < 200; i++)
      step(1'($urandom_range(0, 1)), $urandom_range(1, 9), 1'($urandom_range(0, 1)), "R11", "R11");
    // R1: reset in mid-activity wipes history at the longest tap
    for (int i = 0; i < 100; i++) step(1'($urandom_range(0, 1)), 255, 1'b0, "R3", "R4");
    do_reset();
    for (int i = 0; i < 300; i++) step(1'b0, 255, 1'b0, "R1", "R1");
    @(posedge clk);
    #4;
    done = 1'b1;
    report();
  end
endmodule